// File: doc/BRIEF.md
# Packed 64-bit lane equality comparator

This block compares two source vectors of up to 512 bits, 64 bits at a time, and reports which lanes hold equal values. It has three operating modes. The legacy two-operand mode works on 128 bits and keeps the rest of the prior destination. The three-operand vector mode works on 128 or 256 bits and clears the rest. The mask mode produces one bit per lane instead of a full-width vector, and it can apply a zeroing write-mask and compare every lane against one broadcast element.

A caller presents the operands together with a one-cycle `in_valid` strobe. The result appears on the registered outputs with `out_valid_o` exactly one cycle later, and stays there until the next strobe. A mode and length pair that is not allowed gives zero outputs and a one-cycle error pulse. No status flags are produced.

Top module: `lane_eq_cmp`

## Requirements
- R1: In the legacy mode (`mode_i`=0) and the vector mode (`mode_i`=1), each active 64-bit lane of `vec_o` is all ones when the two source lanes match in all 64 bits, and all zeros otherwise.
- R2: The legacy mode needs `vl_i`=0 (128 bits). It compares lanes 0 and 1 and copies `vec_o[511:128]` from `dest_old_i[511:128]`.
- R3: In the vector mode with `vl_i`=0, lanes 0 and 1 are compared and `vec_o[511:128]` is zero.
- R4: In the vector mode with `vl_i`=1, lanes 0 to 3 are compared and `vec_o[511:256]` is zero.
- R5: In the mask mode (`mode_i`=2), `vl_i`=0, 1 and 2 give 2, 4 and 8 active lanes. `mask_o[j]` is 1 when lane j is active and its sources are equal, and mask bits at or above the active count are 0.
- R6: In the mask mode with `wmask_en_i`=1, a lane whose `wmask_i` bit is 0 gives mask bit 0 (zeroing). With `wmask_en_i`=0, `wmask_i` has no effect.
- R7: In the mask mode with `bcast_i`=1, every lane of `src1_i` is compared against `src2_i[63:0]`.
- R8: `bcast_i` has no effect in the legacy and vector modes, and `wmask_i`/`wmask_en_i` have no effect outside the mask mode.
- R9: `mask_o` is zero in the legacy and vector modes, and `vec_o` is zero in the mask mode.
- R10: The combination is illegal when `mode_i`=3, when `vl_i`=3, when the legacy mode has `vl_i`≠0, or when the vector mode has `vl_i`=2. An illegal combination gives zero `vec_o` and `mask_o`, and `err_o` is high for the single cycle in which `out_valid_o` is high.
- R11: After reset all outputs are zero. `out_valid_o` is high exactly in the cycle after each `in_valid` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operand strobe |
| mode_i | input | 2 | 0 legacy, 1 vector, 2 mask, 3 reserved |
| vl_i | input | 2 | 0 = 128, 1 = 256, 2 = 512 bits, 3 reserved |
| src1_i | input | 512 | First source vector |
| src2_i | input | 512 | Second source vector |
| dest_old_i | input | 512 | Prior destination contents |
| wmask_i | input | 8 | Per-lane write-mask |
| wmask_en_i | input | 1 | Write-mask enable |
| bcast_i | input | 1 | Broadcast of the second operand's low element |
| out_valid_o | output | 1 | Result strobe |
| vec_o | output | 512 | Full-width vector result |
| mask_o | output | 8 | Per-lane mask result |
| err_o | output | 1 | Illegal combination pulse |

## Verification
The compare is tried with these input patterns:
- Fully equal operands and fully different operands, which set the two extreme results.
- Alternating equal and unequal lanes, which expose swapped or misindexed lanes.
- Operands that differ only in bit 63 or bit 0 of a lane, which catch a compare narrower than the full lane.
- Operands that differ only in lanes above the active length, which show that the length bound holds.
- Operands with distinct `dest_old_i` contents, which separate keeping the upper bits from clearing them.

Broadcast cases use lanes that match `src2_i[63:0]` but not their own `src2_i` lane, so that broadcast and normal selection give different results. A random sweep over modes, lengths and masks then runs against an independent model, and the illegal combinations are included in that sweep.

// File: rtl/lane_cmp_pkg.sv
package lane_cmp_pkg;
  typedef enum logic [1:0] {
    MODE_LEGACY = 2'd0,
    MODE_VEC    = 2'd1,
    MODE_MASK   = 2'd2,
    MODE_RSVD   = 2'd3
  } cmp_mode_e;

  typedef enum logic [1:0] {
    VL_128  = 2'd0,
    VL_256  = 2'd1,
    VL_512  = 2'd2,
    VL_RSVD = 2'd3
  } vlen_e;

  // number of lanes covered by a given length code
  function automatic int unsigned lanes_for(vlen_e v, int unsigned lane_w);
    int unsigned bits;
    case (v)
      VL_128:  bits = 128;
      VL_256:  bits = 256;
      VL_512:  bits = 512;
      default: bits = 0;
    endcase
    return bits / lane_w;
  endfunction

  // R10: which mode/length pairs are accepted
  function automatic logic combo_ok(cmp_mode_e m, vlen_e v);
    case (m)
      MODE_LEGACY: return v == VL_128;
      MODE_VEC:    return (v == VL_128) || (v == VL_256);
      MODE_MASK:   return v != VL_RSVD;
      default:     return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/lane_eq_array.sv
module lane_eq_array #(
  parameter int unsigned LANE_W = 64,
  parameter int unsigned NLANES = 8,
  localparam int unsigned VEC_W = LANE_W * NLANES
) (
  input  logic [VEC_W-1:0]  src1,
  input  logic [VEC_W-1:0]  src2,
  input  logic              bcast_sel,
  output logic [NLANES-1:0] eq
);
  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    logic [LANE_W-1:0] opa, opb;
    assign opa   = src1[g*LANE_W +: LANE_W];
    // R7: broadcast selects the low element for every lane
    assign opb   = bcast_sel ? src2[LANE_W-1:0] : src2[g*LANE_W +: LANE_W];
    assign eq[g] = (opa == opb);
  end
endmodule

// File: rtl/cmp_ctrl.sv
module cmp_ctrl
  import lane_cmp_pkg::*;
#(
  parameter int unsigned LANE_W = 64,
  parameter int unsigned NLANES = 8
) (
  input  cmp_mode_e         mode,
  input  vlen_e             vl,
  input  logic [NLANES-1:0] wmask,
  input  logic              wmask_en,
  input  logic              bcast,
  output logic              legal,
  output logic              is_mask,
  output logic              keep_upper,
  output logic              bcast_eff,
  output logic [NLANES-1:0] lane_act,
  output logic [NLANES-1:0] lane_wen
);
  int unsigned n_act;

  always_comb begin
    legal      = combo_ok(mode, vl);
    is_mask    = (mode == MODE_MASK);
    keep_upper = (mode == MODE_LEGACY);
    // R8: broadcast only meaningful in mask mode
    bcast_eff  = bcast && is_mask;
    n_act      = (mode == MODE_LEGACY) ? lanes_for(VL_128, LANE_W) : lanes_for(vl, LANE_W);
    for (int i = 0; i < NLANES; i++) begin
      lane_act[i] = (i < n_act);
      // R6: zeroing mask applies only when enabled in mask mode
      lane_wen[i] = lane_act[i] && (!(wmask_en && is_mask) || wmask[i]);
    end
  end
endmodule

// File: rtl/result_pack.sv
module result_pack #(
  parameter int unsigned LANE_W = 64,
  parameter int unsigned NLANES = 8,
  localparam int unsigned VEC_W = LANE_W * NLANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLANES-1:0] eq,
  input  logic [NLANES-1:0] lane_act,
  input  logic [NLANES-1:0] lane_wen,
  input  logic              legal,
  input  logic              is_mask,
  input  logic              keep_upper,
  input  logic [VEC_W-1:0]  dest_old,
  output logic [VEC_W-1:0]  vec,
  output logic [NLANES-1:0] mask
);
  for (genvar g = 0; g < NLANES; g++) begin : g_pack
    logic [LANE_W-1:0] lane_v;
    always_comb begin
      if (!legal || is_mask)     lane_v = '0;
      else if (lane_act[g])      lane_v = {LANE_W{eq[g]}};
      else if (keep_upper)       lane_v = dest_old[g*LANE_W +: LANE_W];
      else                       lane_v = '0;
    end
    assign vec[g*LANE_W +: LANE_W] = lane_v;
    assign mask[g] = legal && is_mask && lane_wen[g] && eq[g];
  end

  // R5: no mask bit outside the active lanes
  a_r5_mask_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (mask & ~lane_act) == '0);
  // R6: no mask bit on a write-disabled lane
  a_r6_zeroing: assert property (@(posedge clk) disable iff (!rst_n)
    (mask & ~lane_wen) == '0);
endmodule

// File: rtl/lane_eq_cmp.sv
module lane_eq_cmp
  import lane_cmp_pkg::*;
#(
  parameter int unsigned LANE_W = 64,
  parameter int unsigned MAX_VL = 512,
  localparam int unsigned NLANES = MAX_VL / LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        mode_i,
  input  logic [1:0]        vl_i,
  input  logic [MAX_VL-1:0] src1_i,
  input  logic [MAX_VL-1:0] src2_i,
  input  logic [MAX_VL-1:0] dest_old_i,
  input  logic [NLANES-1:0] wmask_i,
  input  logic              wmask_en_i,
  input  logic              bcast_i,
  output logic              out_valid_o,
  output logic [MAX_VL-1:0] vec_o,
  output logic [NLANES-1:0] mask_o,
  output logic              err_o
);
  cmp_mode_e         mode;
  vlen_e             vl;
  logic              legal, is_mask, keep_upper, bcast_eff;
  logic [NLANES-1:0] lane_act, lane_wen, eq;
  logic [MAX_VL-1:0] vec_c;
  logic [NLANES-1:0] mask_c;

  assign mode = cmp_mode_e'(mode_i);
  assign vl   = vlen_e'(vl_i);

  cmp_ctrl #(.LANE_W(LANE_W), .NLANES(NLANES)) u_ctrl (
    .mode(mode), .vl(vl), .wmask(wmask_i), .wmask_en(wmask_en_i), .bcast(bcast_i),
    .legal(legal), .is_mask(is_mask), .keep_upper(keep_upper), .bcast_eff(bcast_eff),
    .lane_act(lane_act), .lane_wen(lane_wen)
  );

  lane_eq_array #(.LANE_W(LANE_W), .NLANES(NLANES)) u_eq (
    .src1(src1_i), .src2(src2_i), .bcast_sel(bcast_eff), .eq(eq)
  );

  result_pack #(.LANE_W(LANE_W), .NLANES(NLANES)) u_pack (
    .clk(clk), .rst_n(rst_n), .eq(eq), .lane_act(lane_act), .lane_wen(lane_wen),
    .legal(legal), .is_mask(is_mask), .keep_upper(keep_upper),
    .dest_old(dest_old_i), .vec(vec_c), .mask(mask_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_o <= 1'b0;
      vec_o       <= '0;
      mask_o      <= '0;
      err_o       <= 1'b0;
    end else begin
      out_valid_o <= in_valid;
      err_o       <= in_valid && !legal;
      if (in_valid) begin
        vec_o  <= vec_c;
        mask_o <= mask_c;
      end
    end
  end

  // R11: one-cycle latency
  a_r11_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid_o);
  a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid_o);
  // R10: error pulse rides the output strobe and zeroes the results
  a_r10_err_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> out_valid_o);
  a_r10_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (vec_o == '0) && (mask_o == '0));
  // R9: only one result kind is nonzero
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> (vec_o == '0) || (mask_o == '0));
  // R2: legacy passes upper bits through
  a_r2_upper_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == MODE_LEGACY && vl == VL_128) |=>
      vec_o[MAX_VL-1:128] == $past(dest_old_i[MAX_VL-1:128]));
  // R4: vector mode clears above 256
  a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == MODE_VEC) |=> vec_o[MAX_VL-1:256] == '0);
endmodule

// File: tb/test_lane_eq_cmp.sv
`timescale 1ns/1ps
module test_lane_eq_cmp;
  localparam int VW = 512;
  localparam int NL = 8;

  typedef struct {
    logic [VW-1:0] vec;
    logic [NL-1:0] mask;
    logic          err;
    int            cyc;
    string         tag;
  } exp_t;

  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [1:0] mode_i = 0, vl_i = 0;
  logic [VW-1:0] src1_i = '0, src2_i = '0, dest_old_i = '0;
  logic [NL-1:0] wmask_i = '0;
  logic wmask_en_i = 0, bcast_i = 0;
  logic out_valid_o, err_o;
  logic [VW-1:0] vec_o;
  logic [NL-1:0] mask_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  exp_t q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lane_eq_cmp i_lane_eq_cmp (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode_i(mode_i), .vl_i(vl_i),
    .src1_i(src1_i), .src2_i(src2_i), .dest_old_i(dest_old_i), .wmask_i(wmask_i),
    .wmask_en_i(wmask_en_i), .bcast_i(bcast_i), .out_valid_o(out_valid_o),
    .vec_o(vec_o), .mask_o(mask_o), .err_o(err_o)
  );

  // independent reference written from the requirements
  function automatic exp_t model(logic [1:0] m, logic [1:0] v, logic [VW-1:0] a,
                                 logic [VW-1:0] b, logic [VW-1:0] old,
                                 logic [NL-1:0] wm, logic wen, logic bc);
    exp_t e;
    int n;
    e.vec = '0; e.mask = '0; e.err = 0;
    if (m == 3 || v == 3 || (m == 0 && v != 0) || (m == 1 && v == 2)) begin
      e.err = 1;  // R10
      return e;
    end
    if (m == 2) begin
      n = (v == 0) ? 2 : (v == 1) ? 4 : 8;
      for (int j = 0; j < n; j++) begin
        logic [63:0] other;
        other = bc ? b[63:0] : b[j*64 +: 64];
        if ((!wen || wm[j]) && a[j*64 +: 64] == other) e.mask[j] = 1'b1;
      end
    end else begin
      n = (v == 0) ? 2 : 4;
      for (int j = 0; j < NL; j++) begin
        if (j < n) e.vec[j*64 +: 64] = (a[j*64 +: 64] == b[j*64 +: 64]) ? {64{1'b1}} : 64'd0;
        else if (m == 0) e.vec[j*64 +: 64] = old[j*64 +: 64];
      end
    end
    return e;
  endfunction

  task automatic send(logic [1:0] m, logic [1:0] v, logic [VW-1:0] a, logic [VW-1:0] b,
                      logic [VW-1:0] old, logic [NL-1:0] wm, logic wen, logic bc,
                      string tag);
    exp_t e;
    @(negedge clk);
    e = model(m, v, a, b, old, wm, wen, bc);
    e.cyc = cyc + 1;
    e.tag = tag;
    q.push_back(e);
    in_valid = 1; mode_i = m; vl_i = v; src1_i = a; src2_i = b; dest_old_i = old;
    wmask_i = wm; wmask_en_i = wen; bcast_i = bc;
    @(negedge clk);
    in_valid = 0;
  endtask

  // monitor: pops expected items when results appear
  always @(negedge clk) begin
    if (rst_n && out_valid_o) begin
      n_chk++;
      if (q.size() == 0) begin
        n_fail++;
        $display("FAIL R11: unexpected out_valid_o, actual 1 expected 0");
      end else begin
        exp_t e;
        e = q.pop_front();
        if (vec_o !== e.vec || mask_o !== e.mask || err_o !== e.err || cyc != e.cyc) begin
          n_fail++;
          $display("FAIL %s: actual vec=%h mask=%h err=%b cyc=%0d expected vec=%h mask=%h err=%b cyc=%0d",
                   e.tag, vec_o, mask_o, err_o, cyc, e.vec, e.mask, e.err, e.cyc);
        end
      end
    end
  end

  function automatic logic [VW-1:0] pat(int seed);
    logic [VW-1:0] r;
    for (int j = 0; j < NL; j++) r[j*64 +: 64] = {32'(seed * 7919 + j * 131), 32'(seed ^ (j * 40503))};
    return r;
  endfunction

  initial begin
    #20000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [VW-1:0] a, b, old, c;
    repeat (3) @(negedge clk);
    n_chk++;  // R11 reset state
    if (out_valid_o !== 0 || vec_o !== '0 || mask_o !== '0 || err_o !== 0) begin
      n_fail++;
      $display("FAIL R11: reset actual v=%b err=%b expected zeros", out_valid_o, err_o);
    end
    rst_n = 1;
    a = pat(1); old = pat(99);
    // R1 / R2 legacy patterns
    send(0, 0, a, a, old, 8'h00, 1, 1, "R1_R2_equal_R8");
    send(0, 0, a, ~a, old, 8'hFF, 0, 0, "R1_R2_differ");
    b = a; b[127] = ~b[127];
    send(0, 0, a, b, old, 8'h00, 0, 0, "R1_top_bit");
    b = a; b[64] = ~b[64]; b[300] = ~b[300];
    send(0, 0, a, b, old, 8'h00, 0, 0, "R2_upper_ignored");
    // R3 / R4 vector modes
    send(1, 0, a, a, old, 8'h00, 1, 1, "R3_equal_R8");
    b = a; b[64 +: 64] = ~b[64 +: 64]; b[192 +: 64] = 64'd5;
    send(1, 1, a, b, old, 8'h00, 0, 0, "R4_alternate");
    b = a; b[511:256] = ~b[511:256];
    send(1, 1, a, b, old, 8'h00, 0, 0, "R4_beyond_len");
    // R5 mask lengths
    b = a; b[64*5] = ~b[64*5];
    send(2, 0, a, b, old, 8'h00, 0, 0, "R5_len128_R9");
    send(2, 1, a, b, old, 8'h00, 0, 0, "R5_len256");
    send(2, 2, a, b, old, 8'h00, 0, 0, "R5_len512");
    // R6 write-mask zeroing and disable
    send(2, 2, a, a, old, 8'hA5, 1, 0, "R6_zeroing");
    send(2, 2, a, a, old, 8'h00, 0, 0, "R6_disabled");
    // R7 broadcast: every src1 lane equals src2 lane 0 only
    c = '0;
    for (int j = 0; j < NL; j++) c[j*64 +: 64] = 64'h1234_5678_9ABC_DEF0;
    b = pat(7); b[63:0] = 64'h1234_5678_9ABC_DEF0;
    send(2, 2, c, b, old, 8'h00, 0, 1, "R7_bcast");
    send(2, 2, c, b, old, 8'h00, 0, 0, "R7_no_bcast");
    send(1, 1, c, b, old, 8'hFF, 1, 1, "R8_bcast_ignored");
    // R10 illegal combinations, back to back
    send(0, 1, a, a, old, 8'h00, 0, 0, "R10_legacy_vl");
    send(1, 2, a, a, old, 8'h00, 0, 0, "R10_vec_512");
    send(3, 0, a, a, old, 8'h00, 0, 0, "R10_mode_rsvd");
    send(2, 3, a, a, old, 8'h00, 0, 0, "R10_vl_rsvd");
    send(2, 2, a, a, old, 8'h00, 0, 0, "R10_after_err");
    // random sweep over all requirements
    for (int k = 0; k < 200; k++) begin
      logic [1:0] m, v;
      m = 2'($urandom_range(0, 3)); v = 2'($urandom_range(0, 3));
      a = pat(k + 10);
      b = a;
      for (int j = 0; j < NL; j++) if ($urandom_range(0, 1)) b[j*64 + $urandom_range(0, 63)] ^= 1'b1;
      send(m, v, a, b, pat(k + 500), 8'($urandom), 1'($urandom), 1'($urandom), "R1_R5_R6_R10_random");
    end
    repeat (4) @(negedge clk);
    n_chk++;
    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL R11: pending results actual %0d expected 0", q.size());
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule